// File: doc/BRIEF.md
# Strap Latch and Clock Mode Controller

This block sits between the board-level configuration straps of a clock synthesizer and its divider and output-enable logic. After reset it waits for an active-low power-good indication. On the first clock where the synchronized power-good reads asserted and no straps are held, it captures the three CPU frequency-select straps, the debug-pair strap and the level of the three-level select input in a single cycle. From that snapshot it produces a symbolic CPU divider code, a flag for the reserved select value, the role of shared output pair 7 and the test-mode controls. It also produces one run enable per output group.

The three-level upper select arrives already resolved into a two-bit level code. Its high level feeds the frequency code. Its mid level arms test mode. Once test mode is armed, the live middle select pin switches in real time between a high-impedance mode and a reference-divided mode. An asynchronous, active-high power-down input overrides everything. It drops every enable and the oscillator enable at once and clears the held straps, so the next power-good assertion captures them again. An active-low PCI stop request gates only the stoppable PCI group. The free-running PCI group keeps running.

Top module: `strap_mode_ctl`

## Requirements
- R1: Out of reset and before any capture, straps_valid_o=0, cpu_code_o=3'b101 (the safe default), rsvd_sel_o=0, pair7_cpu_o=0, test_active_o=0, test_hiz_o=0, test_refdiv_o=0, pll_en_o all 0 and grp_run_o all 0.
- R2: With SYNC_STAGES=2, pwrgd_n_i is first seen low at rising edge E1, and straps_valid_o rises at E3. The strap ports are sampled at that edge.
- R3: Once captured, the held straps do not change until rst_n or pd_i, whatever the strap ports or pwrgd_n_i do.
- R4: The select code is {hi_lvl[1], fsel_mid_i, fsel_lo_i}. The level code is 00 low, 01 mid, 10 high and 11 high. For codes 000 to 110, cpu_code_o equals the code.
- R5: Code 111 sets rsvd_sel_o=1 and drives cpu_code_o=3'b101. cpu_code_o is never 111.
- R6: pair7_cpu_o equals the captured dbg_pair_i: 1 means CPU debug pair and 0 means SRC pair.
- R7: test_active_o=1 exactly when the captured level code is 01 (mid).
- R8: While test mode is active, the live fsel_mid_i, after SYNC_STAGES edges, selects the output mode. A 0 sets test_hiz_o=1 and stops all groups. A 1 sets test_refdiv_o=1 and leaves the groups running. Outside test mode both outputs are 0.
- R9: pd_i=1 forces grp_run_o, pll_en_o, osc_en_o and straps_valid_o to 0 in the same time step, without a clock. After release with pwrgd_n_i still low, the straps are captured again, from their new values, at the third edge.
- R10: The group bit order is 0 CPU, 1 SRC, 2 PCI, 3 free-running PCI, 4 USB, 5 DOT, 6 REF. After SYNC_STAGES edges, pci_stop_n_i=0 clears only bit 2.
- R11: osc_en_o=1 whenever rst_n=1 and pd_i=0, including before capture. osc_en_o is 0 in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrgd_n_i | input | 1 | Active-low power-good; straps valid once low |
| pd_i | input | 1 | Asynchronous active-high power-down |
| fsel_hi_lvl_i | input | 2 | Resolved three-level upper select |
| fsel_mid_i | input | 1 | Middle select strap; live test-mode switch |
| fsel_lo_i | input | 1 | Lower select strap |
| dbg_pair_i | input | 1 | Strap choosing the role of pair 7 |
| pci_stop_n_i | input | 1 | Active-low stop request for stoppable PCI group |
| straps_valid_o | output | 1 | Straps captured and held |
| cpu_code_o | output | 3 | Symbolic CPU divider code |
| rsvd_sel_o | output | 1 | Reserved select code was captured |
| pair7_cpu_o | output | 1 | Pair 7 acts as CPU debug pair |
| test_active_o | output | 1 | Test mode armed |
| test_hiz_o | output | 1 | Test mode, outputs high-impedance |
| test_refdiv_o | output | 1 | Test mode, outputs from reference divider |
| osc_en_o | output | 1 | Crystal oscillator enable |
| pll_en_o | output | NUM_PLL | PLL enables |
| grp_run_o | output | 7 | Per-group run enables |

## Verification
The bench sweeps all eight select codes. A design that passed 111 straight through would hand the dividers an undefined ratio. A design that decoded the wrong level bit would misread a high level as low. It moves every strap and toggles power-good after capture, which exposes a latch that stays transparent or re-arms on a second power-good edge. It also checks, in the same time step, that power-down clears the held straps and that a new capture picks up changed straps. A synchronous power-down would leave the clocks running for a cycle, and a latch not cleared by power-down would keep the stale code. Finally it flips the live test pin and the PCI stop request. That catches a test mode read from the captured value instead of the live pin, and a stop mask that also halts the free-running PCI group.

// File: rtl/strap_mode_pkg.sv
package strap_mode_pkg;
   localparam int GRP_N  = 7;
   localparam int CODE_W = 3;

   typedef enum logic [2:0] {
      GRP_CPU  = 3'd0,
      GRP_SRC  = 3'd1,
      GRP_PCI  = 3'd2,
      GRP_PCIF = 3'd3,
      GRP_USB  = 3'd4,
      GRP_DOT  = 3'd5,
      GRP_REF  = 3'd6
   } grp_e;

   typedef enum logic [1:0] {
      LVL_LOW   = 2'b00,
      LVL_MID   = 2'b01,
      LVL_HIGH  = 2'b10,
      LVL_HIGH2 = 2'b11
   } lvl_e;

   typedef struct packed {
      logic [1:0] hi_lvl;
      logic       mid_b;
      logic       lo_b;
      logic       dbg_pair;
   } strap_t;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= {STAGES{RST_VAL}};
      else         chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/strap_latch.sv
module strap_latch
   import strap_mode_pkg::*;
(
   input  logic   clk,
   input  logic   clr_n,
   input  logic   pg_n_q_i,
   input  strap_t raw_i,
   output logic   valid_o,
   output strap_t held_o
);
   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         valid_o <= 1'b0;
         held_o  <= '0;
      end else if (!valid_o && !pg_n_q_i) begin
         valid_o <= 1'b1;
         held_o  <= raw_i;
      end
   end
endmodule

// File: rtl/mode_decode.sv
module mode_decode
   import strap_mode_pkg::*;
#(
   parameter logic [CODE_W-1:0] SAFE_CODE = 3'b101
) (
   input  logic              valid_i,
   input  strap_t            held_i,
   input  logic              tm_live_i,
   output logic [CODE_W-1:0] cpu_code_o,
   output logic              rsvd_o,
   output logic              pair7_cpu_o,
   output logic              test_active_o,
   output logic              hiz_o,
   output logic              refdiv_o
);
   localparam logic [CODE_W-1:0] RSVD_CODE = '1;
   logic [CODE_W-1:0] sel;

   always_comb begin
      sel           = {held_i.hi_lvl[1], held_i.mid_b, held_i.lo_b};
      rsvd_o        = valid_i && (sel == RSVD_CODE);
      cpu_code_o    = (!valid_i || rsvd_o) ? SAFE_CODE : sel;
      pair7_cpu_o   = valid_i && held_i.dbg_pair;
      test_active_o = valid_i && (held_i.hi_lvl == LVL_MID);
      hiz_o         = test_active_o && !tm_live_i;
      refdiv_o      = test_active_o && tm_live_i;
   end
endmodule

// File: rtl/group_gate.sv
module group_gate
   import strap_mode_pkg::*;
#(
   parameter int               NUM_PLL   = 2,
   parameter logic [GRP_N-1:0] STOP_MASK = 7'b0000100
) (
   input  logic               valid_i,
   input  logic               pd_i,
   input  logic               hiz_i,
   input  logic               pci_run_i,
   output logic [GRP_N-1:0]   grp_run_o,
   output logic [NUM_PLL-1:0] pll_en_o
);
   logic base_run;
   assign base_run = valid_i && !pd_i && !hiz_i;

   for (genvar g = 0; g < GRP_N; g++) begin : g_grp
      if (STOP_MASK[g]) begin : g_stoppable
         assign grp_run_o[g] = base_run && pci_run_i;
      end else begin : g_free
         assign grp_run_o[g] = base_run;
      end
   end

   for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
      assign pll_en_o[p] = valid_i && !pd_i;
   end
endmodule

// File: rtl/strap_mode_ctl.sv
module strap_mode_ctl
   import strap_mode_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter int                NUM_PLL     = 2,
   parameter logic [CODE_W-1:0] SAFE_CODE   = 3'b101,
   parameter logic [GRP_N-1:0]  STOP_MASK   = 7'b0000100
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pwrgd_n_i,
   input  logic               pd_i,
   input  logic [1:0]         fsel_hi_lvl_i,
   input  logic               fsel_mid_i,
   input  logic               fsel_lo_i,
   input  logic               dbg_pair_i,
   input  logic               pci_stop_n_i,
   output logic               straps_valid_o,
   output logic [CODE_W-1:0]  cpu_code_o,
   output logic               rsvd_sel_o,
   output logic               pair7_cpu_o,
   output logic               test_active_o,
   output logic               test_hiz_o,
   output logic               test_refdiv_o,
   output logic               osc_en_o,
   output logic [NUM_PLL-1:0] pll_en_o,
   output logic [GRP_N-1:0]   grp_run_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (NUM_PLL < 1) begin : g_bad_pll
      $error("NUM_PLL must be at least 1");
   end
   if (SAFE_CODE == {CODE_W{1'b1}}) begin : g_bad_safe
      $error("SAFE_CODE must not be the reserved code");
   end

   logic   clr_n;
   logic   pg_n_q;
   logic   tm_q;
   logic   pci_run_q;
   strap_t raw;
   strap_t held;

   assign clr_n = rst_n && !pd_i;
   assign raw   = '{hi_lvl: fsel_hi_lvl_i, mid_b: fsel_mid_i,
                    lo_b: fsel_lo_i, dbg_pair: dbg_pair_i};

   strap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pg_sync (
      .clk(clk), .arst_n(clr_n), .d_i(pwrgd_n_i), .q_o(pg_n_q));

   strap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tm_sync (
      .clk(clk), .arst_n(rst_n), .d_i(fsel_mid_i), .q_o(tm_q));

   strap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stop_sync (
      .clk(clk), .arst_n(rst_n), .d_i(pci_stop_n_i), .q_o(pci_run_q));

   strap_latch u_latch (
      .clk(clk), .clr_n(clr_n), .pg_n_q_i(pg_n_q), .raw_i(raw),
      .valid_o(straps_valid_o), .held_o(held));

   mode_decode #(.SAFE_CODE(SAFE_CODE)) u_dec (
      .valid_i(straps_valid_o), .held_i(held), .tm_live_i(tm_q),
      .cpu_code_o(cpu_code_o), .rsvd_o(rsvd_sel_o),
      .pair7_cpu_o(pair7_cpu_o), .test_active_o(test_active_o),
      .hiz_o(test_hiz_o), .refdiv_o(test_refdiv_o));

   group_gate #(.NUM_PLL(NUM_PLL), .STOP_MASK(STOP_MASK)) u_gate (
      .valid_i(straps_valid_o), .pd_i(pd_i), .hiz_i(test_hiz_o),
      .pci_run_i(pci_run_q), .grp_run_o(grp_run_o), .pll_en_o(pll_en_o));

   assign osc_en_o = rst_n && !pd_i;
endmodule

// File: rtl/strap_mode_chk.sv
module strap_mode_chk
   import strap_mode_pkg::*;
#(
   parameter int                NUM_PLL   = 2,
   parameter logic [CODE_W-1:0] SAFE_CODE = 3'b101
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pd_i,
   input logic               straps_valid_o,
   input logic [CODE_W-1:0]  cpu_code_o,
   input logic               rsvd_sel_o,
   input logic               pair7_cpu_o,
   input logic               test_active_o,
   input logic               test_hiz_o,
   input logic               test_refdiv_o,
   input logic               osc_en_o,
   input logic [NUM_PLL-1:0] pll_en_o,
   input logic [GRP_N-1:0]   grp_run_o
);
   AST_NO_RUN_UNLATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      !straps_valid_o |-> (grp_run_o == '0 && pll_en_o == '0 && !test_active_o && !rsvd_sel_o)); // R1
   AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || pd_i)
      straps_valid_o |=> straps_valid_o); // R3
   AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n || pd_i)
      straps_valid_o |=> ($stable(cpu_code_o) && $stable(pair7_cpu_o) && $stable(test_active_o))); // R3
   AST_CODE_NOT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_code_o != 3'b111); // R5
   AST_RSVD_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
      rsvd_sel_o |-> cpu_code_o == SAFE_CODE); // R5
   AST_PAIR7_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      pair7_cpu_o |-> straps_valid_o); // R6
   AST_HIZ_ALL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      test_hiz_o |-> grp_run_o == '0); // R8
   AST_TEST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({test_hiz_o, test_refdiv_o}) == (test_active_o ? 1 : 0)); // R8
   AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      pd_i |-> (grp_run_o == '0 && pll_en_o == '0 && !osc_en_o && !straps_valid_o)); // R9
   AST_FREE_PCI: assert property (@(posedge clk) disable iff (!rst_n)
      (straps_valid_o && !pd_i && !test_hiz_o) |-> grp_run_o[GRP_PCIF]); // R10
endmodule

bind strap_mode_ctl strap_mode_chk #(.NUM_PLL(NUM_PLL), .SAFE_CODE(SAFE_CODE)) u_chk (
   .clk(clk), .rst_n(rst_n), .pd_i(pd_i), .straps_valid_o(straps_valid_o),
   .cpu_code_o(cpu_code_o), .rsvd_sel_o(rsvd_sel_o), .pair7_cpu_o(pair7_cpu_o),
   .test_active_o(test_active_o), .test_hiz_o(test_hiz_o),
   .test_refdiv_o(test_refdiv_o), .osc_en_o(osc_en_o), .pll_en_o(pll_en_o),
   .grp_run_o(grp_run_o));

// File: tb/sim_strap_mode_ctl.sv
module sim_strap_mode_ctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwrgd_n_i = 1'b1;
   logic       pd_i = 1'b0;
   logic [1:0] fsel_hi_lvl_i = 2'b00;
   logic       fsel_mid_i = 1'b0;
   logic       fsel_lo_i = 1'b0;
   logic       dbg_pair_i = 1'b0;
   logic       pci_stop_n_i = 1'b1;
   logic       straps_valid_o, rsvd_sel_o, pair7_cpu_o, test_active_o;
   logic       test_hiz_o, test_refdiv_o, osc_en_o;
   logic [2:0] cpu_code_o;
   logic [1:0] pll_en_o;
   logic [6:0] grp_run_o;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   strap_mode_ctl u0 (
      .clk(clk), .rst_n(rst_n), .pwrgd_n_i(pwrgd_n_i), .pd_i(pd_i),
      .fsel_hi_lvl_i(fsel_hi_lvl_i), .fsel_mid_i(fsel_mid_i),
      .fsel_lo_i(fsel_lo_i), .dbg_pair_i(dbg_pair_i),
      .pci_stop_n_i(pci_stop_n_i), .straps_valid_o(straps_valid_o),
      .cpu_code_o(cpu_code_o), .rsvd_sel_o(rsvd_sel_o),
      .pair7_cpu_o(pair7_cpu_o), .test_active_o(test_active_o),
      .test_hiz_o(test_hiz_o), .test_refdiv_o(test_refdiv_o),
      .osc_en_o(osc_en_o), .pll_en_o(pll_en_o), .grp_run_o(grp_run_o));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_straps(input logic [1:0] lvl, input logic mid, input logic lo, input logic dbg);
      fsel_hi_lvl_i = lvl; fsel_mid_i = mid; fsel_lo_i = lo; dbg_pair_i = dbg;
   endtask

   // clear via power-down, set straps, then assert power-good; valid after 3 edges
   task automatic capture(input logic [1:0] lvl, input logic mid, input logic lo, input logic dbg);
      @(negedge clk); pd_i = 1'b1; pwrgd_n_i = 1'b1;
      set_straps(lvl, mid, lo, dbg);
      @(negedge clk); pd_i = 1'b0;
      @(negedge clk); pwrgd_n_i = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset;
      #2 chk("R11 osc off in reset", osc_en_o, 0);
      repeat (2) @(negedge clk); rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 valid", straps_valid_o, 0);
      chk("R1 code", cpu_code_o, 3'b101);
      chk("R1 flags", {rsvd_sel_o, pair7_cpu_o, test_active_o, test_hiz_o, test_refdiv_o}, 0);
      chk("R1 groups", grp_run_o, 0);
      chk("R1 plls", pll_en_o, 0);
      chk("R11 osc on before capture", osc_en_o, 1);
   endtask

   task automatic t_capture_timing;
      set_straps(2'b00, 1'b1, 1'b1, 1'b0);
      @(negedge clk); pwrgd_n_i = 1'b0;
      repeat (2) @(negedge clk);
      chk("R2 not yet valid after 2 edges", straps_valid_o, 0);
      @(negedge clk);
      chk("R2 valid at third edge", straps_valid_o, 1);
      chk("R2 code sampled", cpu_code_o, 3'd3);
      chk("R2 groups run", grp_run_o, 7'h7F);
      chk("R2 plls on", pll_en_o, 2'b11);
   endtask

   task automatic t_codes;
      for (int k = 0; k < 8; k++) begin
         logic [2:0] c;
         c = 3'(k);
         capture(c[2] ? 2'b10 : 2'b00, c[1], c[0], 1'b0);
         chk(k == 7 ? "R5 reserved code" : "R4 code pass", cpu_code_o, (k == 7) ? 3'b101 : c);
         chk(k == 7 ? "R5 reserved flag" : "R4 no reserved flag", rsvd_sel_o, (k == 7) ? 1 : 0);
         chk("R7 no test on low/high", test_active_o, 0);
      end
      capture(2'b11, 1'b0, 1'b1, 1'b0);
      chk("R4 level 11 counts as high", cpu_code_o, 3'b101);
      chk("R7 level 11 no test", test_active_o, 0);
   endtask

   task automatic t_frozen;
      capture(2'b00, 1'b1, 1'b1, 1'b0);
      @(negedge clk); set_straps(2'b01, 1'b0, 1'b0, 1'b1);
      @(negedge clk); pwrgd_n_i = 1'b1;
      repeat (3) @(negedge clk); pwrgd_n_i = 1'b0;
      repeat (5) @(negedge clk);
      chk("R3 code frozen", cpu_code_o, 3'd3);
      chk("R3 pair7 frozen", pair7_cpu_o, 0);
      chk("R3 test frozen", test_active_o, 0);
      chk("R3 valid kept", straps_valid_o, 1);
   endtask

   task automatic t_pair7;
      capture(2'b10, 1'b1, 1'b0, 1'b1);
      chk("R6 pair7 cpu", pair7_cpu_o, 1);
      chk("R4 code 110", cpu_code_o, 3'b110);
      capture(2'b10, 1'b1, 1'b0, 1'b0);
      chk("R6 pair7 src", pair7_cpu_o, 0);
   endtask

   task automatic t_test_mode;
      capture(2'b01, 1'b1, 1'b0, 1'b1);
      chk("R7 test armed by mid", test_active_o, 1);
      chk("R4 mid gives upper bit 0", cpu_code_o, 3'b010);
      chk("R8 refdiv", {test_hiz_o, test_refdiv_o}, 2'b01);
      chk("R8 refdiv groups run", grp_run_o, 7'h7F);
      @(negedge clk); fsel_mid_i = 1'b0;
      @(negedge clk);
      chk("R8 live pin not yet through", test_refdiv_o, 1);
      @(negedge clk);
      chk("R8 hiz", {test_hiz_o, test_refdiv_o}, 2'b10);
      chk("R8 hiz stops groups", grp_run_o, 0);
      chk("R3 code frozen in test", cpu_code_o, 3'b010);
      @(negedge clk); fsel_mid_i = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8 back to refdiv", {test_hiz_o, test_refdiv_o}, 2'b01);
   endtask

   task automatic t_power_down;
      capture(2'b00, 1'b0, 1'b1, 1'b1);
      chk("R4 code 001", cpu_code_o, 3'b001);
      #3 pd_i = 1'b1;
      #1;
      chk("R9 valid cleared async", straps_valid_o, 0);
      chk("R9 groups off async", grp_run_o, 0);
      chk("R9 plls off async", pll_en_o, 0);
      chk("R9 osc off async", osc_en_o, 0);
      chk("R9 pair7 cleared", pair7_cpu_o, 0);
      set_straps(2'b10, 1'b1, 1'b0, 1'b0);
      @(negedge clk); @(negedge clk); pd_i = 1'b0;
      #1 chk("R11 osc back on", osc_en_o, 1);
      @(negedge clk); @(negedge clk);
      chk("R9 not recaptured after 2 edges", straps_valid_o, 0);
      @(negedge clk);
      chk("R9 recaptured", straps_valid_o, 1);
      chk("R9 new code", cpu_code_o, 3'b110);
   endtask

   task automatic t_pci_stop;
      capture(2'b10, 1'b0, 1'b1, 1'b0);
      @(negedge clk); pci_stop_n_i = 1'b0;
      @(negedge clk);
      chk("R10 stop not yet through", grp_run_o, 7'h7F);
      @(negedge clk);
      chk("R10 only PCI stopped", grp_run_o, 7'h7B);
      @(negedge clk); pci_stop_n_i = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 PCI resumes", grp_run_o, 7'h7F);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R1-all: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_capture_timing();
      t_codes();
      t_frozen();
      t_pair7();
      t_test_mode();
      t_power_down();
      t_pci_stop();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule